// File: doc/BRIEF.md
# Active Image Window Gate

This block sits on a raster pixel stream that carries a per-line enable strobe and a per-frame enable strobe. It passes on only the pixels that fall inside a programmed rectangle, together with a registered valid qualifier, a pulse on the first passed pixel of each processed line, and a pulse when the frame window is finished.

The rectangle is described by four values: a horizontal skip count, a horizontal pass count, a vertical skip count and a vertical pass count. They are loaded a byte at a time through a 4-bit register index while the block is idle. A vertical pass count of zero leaves the bottom of the window open, so the window then ends when the frame enable drops. During each frame the block counts the lines it processed. The count can be read back through the same index afterwards.

The block is idle until it sees a rising frame enable. It is busy from then until its frame-done pulse.

Top module: `active_window_gate`

## Requirements
- R1: After reset, `pix_valid`, `line_start` and `frame_done` are 0, and every register index reads back 0.
- R2: Register map, all byte-wide and readable on `reg_rdata` as soon as `reg_idx` is applied. Index 0 holds horizontal skip bits 7:0 and index 1 holds its bits 12:8 in data bits 4:0. Index 2 holds horizontal pass bits 7:0 and index 3 holds its bits 14:8 in data bits 6:0. Index 4 holds vertical skip bits 7:0 and index 5 holds its bits 12:8 in data bits 4:0. Index 6 holds vertical pass bits 7:0 and index 7 holds its bits 12:8 in data bits 4:0. Unused upper data bits are dropped on write and read back as 0.
- R3: Index 8 reads the processed-line count bits 7:0 and index 9 reads its bits 13:8. Writes to indices 8 to 15 have no effect, and indices 10 to 15 read 0.
- R4: Lines in a frame are numbered from 0 at each rising line enable after the frame starts. Line k is processed when skipV <= k < skipV + passV, or when skipV <= k with passV = 0.
- R5: Within a processed line, pixel p is the pixel sampled p cycles after the cycle in which line enable is first seen high (that cycle is p = 0). It is passed when skipH <= p < skipH + passH and line enable is still high. A passed pixel appears on `pix_out` with `pix_valid` high one cycle after it was sampled.
- R6: `line_start` is high together with `pix_valid` for the first passed pixel of each processed line, and at no other time.
- R7: With passV = 0, the window ends when frame enable is sampled low. `frame_done` is high in the following cycle.
- R8: With passV != 0, `frame_done` pulses once, one cycle after line enable is sampled low at the end of line skipV + passV - 1. The block is then idle, and later lines of the same frame produce nothing.
- R9: The processed-line count is cleared at frame start and increments once per processed line.
- R10: Register writes while the block is busy are ignored.
- R11: Lines that arrive while the block is idle produce no valid pixels and no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_en | input | 1 | Line enable strobe, high while a line's pixels are on `pix_in` |
| frame_en | input | 1 | Frame enable strobe; a rising edge starts a frame |
| pix_in | input | 16 | Input pixel data |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register readback for `reg_idx` |
| pix_valid | output | 1 | Registered pixel qualifier |
| pix_out | output | 16 | Registered pixel data |
| line_start | output | 1 | First passed pixel of a processed line |
| frame_done | output | 1 | One-cycle end-of-window pulse |

## Verification
A wrong horizontal position count shows up one cycle after the affected pixel. It appears as a shifted, missing or extra entry in the valid pixel stream, so the scoreboard sees it at the very first line. A wrong line counter or vertical compare adds or drops whole lines of pixels. It also moves the `frame_done` pulse, which is checked in the exact cycle after the line that should close the window. A lost busy state shows up later: writes that should be ignored change the readback, and idle lines leak pixels.

// File: rtl/awg_pkg.sv
package awg_pkg;

  // Pixel position test shared by both counters: pos lies in [start, start+len).
  function automatic logic in_span(input logic [31:0] pos,
                                   input logic [31:0] start,
                                   input logic [31:0] len);
    return (pos >= start) && ((pos - start) < len);
  endfunction

  // Index of the line that closes a bounded window.
  function automatic logic [31:0] last_line(input logic [31:0] skip,
                                            input logic [31:0] pass);
    return skip + pass - 32'd1;
  endfunction

endpackage

// File: rtl/awg_regs.sv
module awg_regs #(
  parameter int HD_W = 13,
  parameter int HW_W = 15,
  parameter int VD_W = 13,
  parameter int VW_W = 13,
  parameter int LN_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  logic            reg_wr,
  input  logic [3:0]      reg_idx,
  input  logic [7:0]      reg_wdata,
  input  logic [LN_W-1:0] lines_done,
  output logic [7:0]      reg_rdata,
  output logic [HD_W-1:0] hdelay,
  output logic [HW_W-1:0] hwidth,
  output logic [VD_W-1:0] vdelay,
  output logic [VW_W-1:0] vwidth
);

  logic wr_take;
  assign wr_take = reg_wr && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdelay <= '0;
      hwidth <= '0;
      vdelay <= '0;
      vwidth <= '0;
    end else if (wr_take) begin
      case (reg_idx)
        4'd0: hdelay[7:0]      <= reg_wdata;
        4'd1: hdelay[HD_W-1:8] <= reg_wdata[HD_W-9:0];
        4'd2: hwidth[7:0]      <= reg_wdata;
        4'd3: hwidth[HW_W-1:8] <= reg_wdata[HW_W-9:0];
        4'd4: vdelay[7:0]      <= reg_wdata;
        4'd5: vdelay[VD_W-1:8] <= reg_wdata[VD_W-9:0];
        4'd6: vwidth[7:0]      <= reg_wdata;
        4'd7: vwidth[VW_W-1:8] <= reg_wdata[VW_W-9:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_idx)
      4'd0:    reg_rdata = hdelay[7:0];
      4'd1:    reg_rdata = 8'(hdelay >> 8);
      4'd2:    reg_rdata = hwidth[7:0];
      4'd3:    reg_rdata = 8'(hwidth >> 8);
      4'd4:    reg_rdata = vdelay[7:0];
      4'd5:    reg_rdata = 8'(vdelay >> 8);
      4'd6:    reg_rdata = vwidth[7:0];
      4'd7:    reg_rdata = 8'(vwidth >> 8);
      4'd8:    reg_rdata = lines_done[7:0];
      4'd9:    reg_rdata = 8'(lines_done >> 8);
      default: reg_rdata = 8'h00;
    endcase
  end

  // R10
  busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && busy) |=> ($stable(hdelay) && $stable(hwidth) &&
                          $stable(vdelay) && $stable(vwidth)));

endmodule

// File: rtl/awg_frame.sv
module awg_frame
  import awg_pkg::*;
#(
  parameter int VD_W = 13,
  parameter int VW_W = 13,
  parameter int LN_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_en,
  input  logic            le_rise,
  input  logic            le_fall,
  input  logic [VD_W-1:0] vdelay,
  input  logic [VW_W-1:0] vwidth,
  output logic            busy,
  output logic            act_now,
  output logic [LN_W-1:0] lines_done,
  output logic            frame_done
);

  logic            fe_q;
  logic [LN_W-1:0] vcnt;
  logic            line_act;
  logic            last_q;

  logic fe_rise, fe_fall, start, v_ok, line_hit, is_last, end_now;
  logic [31:0] v_len;

  assign fe_rise  = frame_en && !fe_q;
  assign fe_fall  = !frame_en && fe_q;
  assign start    = fe_rise && !busy;
  assign v_len    = (vwidth == '0) ? 32'hFFFF_FFFF : 32'(vwidth);
  assign v_ok     = in_span(32'(vcnt), 32'(vdelay), v_len);
  assign line_hit = busy && le_rise && v_ok;
  assign is_last  = (vwidth != '0) &&
                    (32'(vcnt) == last_line(32'(vdelay), 32'(vwidth)));
  assign end_now  = busy && ((le_fall && line_act && last_q) || fe_fall);
  assign act_now  = le_rise ? line_hit : line_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fe_q       <= 1'b0;
      busy       <= 1'b0;
      vcnt       <= '0;
      line_act   <= 1'b0;
      last_q     <= 1'b0;
      lines_done <= '0;
      frame_done <= 1'b0;
    end else begin
      fe_q       <= frame_en;
      frame_done <= end_now;
      if (start) begin
        busy       <= 1'b1;
        vcnt       <= '0;
        line_act   <= 1'b0;
        last_q     <= 1'b0;
        lines_done <= '0;
      end else if (end_now) begin
        busy     <= 1'b0;
        line_act <= 1'b0;
      end else if (busy) begin
        if (le_rise) begin
          vcnt     <= vcnt + 1'b1;
          line_act <= line_hit;
          last_q   <= line_hit && is_last;
          if (line_hit) lines_done <= lines_done + 1'b1;
        end else if (le_fall) begin
          line_act <= 1'b0;
        end
      end
    end
  end

  // R8
  done_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy);

  // R9
  line_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && vwidth != '0) |-> (32'(lines_done) <= 32'(vwidth)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

endmodule

// File: rtl/awg_line.sv
module awg_line
  import awg_pkg::*;
#(
  parameter int PIX_W  = 16,
  parameter int HD_W   = 13,
  parameter int HW_W   = 15,
  parameter int HPOS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_en,
  input  logic             le_rise,
  input  logic             act_now,
  input  logic [HD_W-1:0]  hdelay,
  input  logic [HW_W-1:0]  hwidth,
  input  logic [PIX_W-1:0] pix_in,
  output logic             pix_valid,
  output logic [PIX_W-1:0] pix_out,
  output logic             line_start
);

  localparam logic [HPOS_W-1:0] HMAX = {HPOS_W{1'b1}};

  logic [HPOS_W-1:0] hcnt;
  logic [HPOS_W-1:0] hpos_now;
  logic              pass;
  logic              first;

  assign hpos_now = le_rise ? '0 : hcnt;
  assign pass     = line_en && act_now &&
                    in_span(32'(hpos_now), 32'(hdelay), 32'(hwidth));
  assign first    = pass && (32'(hpos_now) == 32'(hdelay));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt       <= '0;
      pix_valid  <= 1'b0;
      pix_out    <= '0;
      line_start <= 1'b0;
    end else begin
      if (line_en) hcnt <= (hpos_now == HMAX) ? HMAX : hpos_now + 1'b1;
      pix_valid  <= pass;
      pix_out    <= pass ? pix_in : '0;
      line_start <= first;
    end
  end

  // R5
  valid_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(line_en));

  // R6
  start_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> pix_valid);

  // R6
  rise_is_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> line_start);

endmodule

// File: rtl/active_window_gate.sv
module active_window_gate #(
  parameter int PIX_W  = 16,
  parameter int HD_W   = 13,
  parameter int HW_W   = 15,
  parameter int VD_W   = 13,
  parameter int VW_W   = 13,
  parameter int LN_W   = 14,
  parameter int HPOS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_en,
  input  logic             frame_en,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             reg_wr,
  input  logic [3:0]       reg_idx,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             pix_valid,
  output logic [PIX_W-1:0] pix_out,
  output logic             line_start,
  output logic             frame_done
);

  logic            le_q;
  logic            le_rise, le_fall;
  logic            busy, act_now;
  logic [HD_W-1:0] hdelay;
  logic [HW_W-1:0] hwidth;
  logic [VD_W-1:0] vdelay;
  logic [VW_W-1:0] vwidth;
  logic [LN_W-1:0] lines_done;

  always_ff @(posedge clk) begin
    if (!rst_n) le_q <= 1'b0;
    else        le_q <= line_en;
  end

  assign le_rise = line_en && !le_q;
  assign le_fall = !line_en && le_q;

  awg_regs #(.HD_W(HD_W), .HW_W(HW_W), .VD_W(VD_W), .VW_W(VW_W), .LN_W(LN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .busy(busy), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .lines_done(lines_done), .reg_rdata(reg_rdata),
    .hdelay(hdelay), .hwidth(hwidth), .vdelay(vdelay), .vwidth(vwidth));

  awg_frame #(.VD_W(VD_W), .VW_W(VW_W), .LN_W(LN_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .le_rise(le_rise),
    .le_fall(le_fall), .vdelay(vdelay), .vwidth(vwidth), .busy(busy),
    .act_now(act_now), .lines_done(lines_done), .frame_done(frame_done));

  awg_line #(.PIX_W(PIX_W), .HD_W(HD_W), .HW_W(HW_W), .HPOS_W(HPOS_W)) u_line (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .le_rise(le_rise),
    .act_now(act_now), .hdelay(hdelay), .hwidth(hwidth), .pix_in(pix_in),
    .pix_valid(pix_valid), .pix_out(pix_out), .line_start(line_start));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !pix_valid);

endmodule

// File: tb/active_window_gate_tb.sv
module active_window_gate_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_en = 1'b0;
  logic        frame_en = 1'b0;
  logic [15:0] pix_in = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        pix_valid;
  logic [15:0] pix_out;
  logic        line_start;
  logic        frame_done;

  always #4 clk = ~clk;

  active_window_gate u_dut (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .frame_en(frame_en),
    .pix_in(pix_in), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pix_valid(pix_valid), .pix_out(pix_out),
    .line_start(line_start), .frame_done(frame_done));

  int n_chk = 0;
  int n_bad = 0;
  logic [16:0] sb_q[$];

  int hd, hw, vd, vw;
  int k_line, lines_e;
  bit busy_e = 0;
  logic [15:0] seq = 16'h0100;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected pixels as the design emits them.
  always @(negedge clk) begin
    if (rst_n) begin
      if (pix_valid) begin
        if (sb_q.size() == 0) begin
          check(0, "R5 unexpected pixel", int'(pix_out), 0);
        end else begin
          logic [16:0] e;
          e = sb_q.pop_front();
          check({line_start, pix_out} == e, "R5/R6 pixel", int'({line_start, pix_out}), int'(e));
        end
      end else if (line_start) begin
        check(0, "R6 start without valid", 1, 0);
      end
    end
  end

  task automatic wr(input int idx, input int val);
    @(negedge clk);
    reg_idx = 4'(idx); reg_wdata = 8'(val); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input int idx, input int exp, input string req);
    @(negedge clk);
    reg_idx = 4'(idx);
    #1;
    check(reg_rdata == 8'(exp), req, int'(reg_rdata), exp);
  endtask

  task automatic set_win(input int a, input int b, input int c, input int d);
    hd = a; hw = b; vd = c; vw = d;
    wr(0, a); wr(1, a >> 8); wr(2, b); wr(3, b >> 8);
    wr(4, c); wr(5, c >> 8); wr(6, d); wr(7, d >> 8);
  endtask

  // Driver: one line of len pixels, then gap idle cycles (gap >= 1).
  task automatic do_line(input int len, input int gap);
    bit act, last;
    act  = busy_e && (k_line >= vd) && (vw == 0 || k_line < vd + vw);
    last = act && (vw != 0) && (k_line == vd + vw - 1);
    for (int p = 0; p < len; p++) begin
      @(negedge clk);
      line_en = 1'b1; pix_in = seq;
      if (act && p >= hd && p < hd + hw) sb_q.push_back({(p == hd), seq});
      seq++;
    end
    @(negedge clk);
    line_en = 1'b0; pix_in = '0;
    if (busy_e) begin
      k_line++;
      if (act) lines_e++;
    end
    @(negedge clk);
    // R8: close pulse exactly one cycle after the last line ends
    check(frame_done == last, "R8 frame_done after line", int'(frame_done), int'(last));
    if (last) busy_e = 0;
    for (int g = 1; g < gap; g++) @(negedge clk);
  endtask

  task automatic frame_begin();
    @(negedge clk); frame_en = 1'b1;
    @(negedge clk); busy_e = 1; k_line = 0; lines_e = 0;
    @(negedge clk);
  endtask

  task automatic frame_end(input string req);
    bit exp;
    @(negedge clk); frame_en = 1'b0;
    exp = busy_e;
    @(negedge clk);
    check(frame_done == exp, req, int'(frame_done), int'(exp));
    busy_e = 0;
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R4/R5 pixels missing", sb_q.size(), 0);
    // R9 line count readback
    rd_chk(8, lines_e & 8'hFF, "R9 count low");
    rd_chk(9, lines_e >> 8, "R9 count high");
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(pix_valid == 0 && line_start == 0 && frame_done == 0, "R1 outputs",
          int'({pix_valid, line_start, frame_done}), 0);
    for (int i = 0; i < 16; i++) rd_chk(i, 0, "R1 readback");

    // R2 map and masking of unused upper bits
    wr(1, 8'hFF); rd_chk(1, 8'h1F, "R2 idx1 mask");
    wr(3, 8'hFF); rd_chk(3, 8'h7F, "R2 idx3 mask");
    wr(5, 8'hFF); rd_chk(5, 8'h1F, "R2 idx5 mask");
    wr(7, 8'hFF); rd_chk(7, 8'h1F, "R2 idx7 mask");
    wr(2, 8'hA5); rd_chk(2, 8'hA5, "R2 idx2");
    // R3 read-only and unused indices
    wr(8, 8'h55); rd_chk(8, 0, "R3 idx8 read-only");
    wr(12, 8'h5A); rd_chk(12, 0, "R3 idx12 reads 0");

    // Frame A: bounded window
    set_win(3, 5, 2, 3);
    // R11: a line while idle passes nothing
    do_line(12, 3);
    frame_begin();
    for (int l = 0; l < 7; l++) do_line(12, 3);   // R4, R5, R6, R8, R11 (lines 5,6)
    frame_end("R8 no second pulse");
    check(lines_e == 3, "R9 bench count", lines_e, 3);

    // Frame B: open bottom, line shorter than the pass span
    set_win(0, 10, 1, 0);
    frame_begin();
    for (int l = 0; l < 4; l++) do_line(6, 2);
    frame_end("R7 frame_done at frame end");

    // Frame C: zero pass width, busy writes ignored
    set_win(7, 0, 0, 2);
    frame_begin();
    do_line(10, 2);
    wr(0, 8'h77);   // R10 ignored while busy
    wr(6, 8'h09);
    do_line(10, 2);
    do_line(10, 2);
    frame_end("R8 frame C");
    rd_chk(0, 7, "R10 hdelay unchanged");
    rd_chk(6, 2, "R10 vwidth unchanged");

    // Frame D: skip count above one byte
    set_win(260, 3, 0, 1);
    rd_chk(1, 1, "R2 idx1 value");
    frame_begin();
    do_line(270, 2);
    do_line(270, 2);
    frame_end("R8 frame D");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule